// File: doc/BRIEF.md
# Indexed Display Register Decoder

This block sits behind a local byte-write bus and turns single byte accesses into updates of several banks of indexed registers for a display controller. Five banks each have their own pair of bus offsets: software first writes a register number to the bank's index offset, and later writes to the bank's data offset land in the register that number selects. A sixth bank, used for attribute settings, has only one offset. A phase flag decides whether a byte written there is taken as an index or as data. The flag flips on every such write. A read of a separate status offset puts it back into the index phase, so software can always find a known starting point.

There is also one standalone byte register for miscellaneous output control. A bit in the attribute index byte drives a video enable output. Every bank register appears on one wide flat output bus for the downstream display logic. Reads return the current index of a bank, the miscellaneous register or the phase flag. Data offsets are write-only.

Top module: `disp_reg_decoder`

## Requirements
- R1: After reset every bank register, every bank index, the miscellaneous register and the video enable are zero, and the attribute phase is the index phase (a status read returns 0).
- R2: A write to a bank's index offset stores the low INDEX_W bits of the byte as that bank's index. A read of that offset returns the index zero-extended to 8 bits.
- R3: A write to a bank's data offset updates only the register its index selects. No other register of any bank changes.
- R4: Offsets (index/data): bank 0 at 0x7AC/0x7AD, bank 1 at 0x7A0/0x7A1, bank 2 at 0x7A8/0x7A9, bank 3 at 0x79C/0x79D, bank 4 at 0x788/0x789. Register i of bank b is regFlat[(b*2^INDEX_W+i)*8 +: 8].
- R5: Offset 0x780 reaches bank 5. A write there in the index phase sets the bank 5 index. A write in the data phase writes the selected bank 5 register. Every write there flips the phase, and a read of 0x780 returns the bank 5 index.
- R6: A read of 0x7B4 returns the phase in bit 0 (1 = data phase), with the other bits zero. After that read the phase is the index phase.
- R7: An index-phase write to 0x780 copies bit 5 of the byte to videoEnable. Data-phase writes leave videoEnable unchanged.
- R8: Offset 0x784 is a read/write byte register that drives miscOut.
- R9: Writes to undecoded offsets change nothing. Reads of undecoded offsets, reads of data offsets, and the output while rdEn is low all give zero.
- R10: The index does not advance on a data write. Repeated data writes hit the same register, and the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 8 | Write byte |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read byte, valid in the cycle rdEn is high |
| miscOut | output | 8 | Miscellaneous output register |
| videoEnable | output | 1 | Video output enable from the attribute index byte |
| regFlat | output | 6*2^INDEX_W*8 | All bank registers, bank-major |

## Verification
The bench builds the block with INDEX_W = 4, which gives 16 registers per bank. This lets the whole register image of all six banks be compared against a model after every step. Index bytes with the upper nibble set then exercise the truncation rule of R2. ADDR_W stays at 12, so offsets that lie next to decoded ones, such as 0x7AE and 0x7B0, can be used to probe the undecoded cases. A pseudo-random write run over the decoded offsets, with status reads mixed in, shows that the phase flag and the per-bank indices stay consistent over long mixed sequences.

// File: rtl/disp_regdec_pkg.sv
package disp_regdec_pkg;
  localparam int NBANK = 6;
  localparam int ATTR_BANK = 5;
  localparam logic [11:0] ATTR_ADDR   = 12'h780;
  localparam logic [11:0] MISC_ADDR   = 12'h784;
  localparam logic [11:0] STATUS_ADDR = 12'h7B4;

  // Index offset of each paired bank; data offset is the next byte.
  function automatic logic [11:0] idxAddr(input int b);
    case (b)
      0: idxAddr = 12'h7AC;
      1: idxAddr = 12'h7A0;
      2: idxAddr = 12'h7A8;
      3: idxAddr = 12'h79C;
      4: idxAddr = 12'h788;
      default: idxAddr = ATTR_ADDR;
    endcase
  endfunction

  typedef struct packed {
    logic [NBANK-1:0] idxWr;
    logic [NBANK-1:0] datWr;
    logic [NBANK-1:0] idxRd;
    logic             miscWr;
    logic             miscRd;
    logic             statRd;
  } strobe_t;
endpackage

// File: rtl/disp_regdec_ctrl.sv
module disp_regdec_ctrl
  import disp_regdec_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           stb,
  output logic              attrPhase
);
  logic attrHit;
  assign attrHit = (addr == ADDR_W'(ATTR_ADDR));

  always_comb begin
    stb = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (b != ATTR_BANK) begin
        stb.idxWr[b] = wrEn && (addr == ADDR_W'(idxAddr(b)));
        stb.datWr[b] = wrEn && (addr == ADDR_W'(idxAddr(b) + 12'd1));
        stb.idxRd[b] = rdEn && (addr == ADDR_W'(idxAddr(b)));
      end
    end
    stb.idxWr[ATTR_BANK] = wrEn && attrHit && !attrPhase;
    stb.datWr[ATTR_BANK] = wrEn && attrHit && attrPhase;
    stb.idxRd[ATTR_BANK] = rdEn && attrHit;
    stb.miscWr = wrEn && (addr == ADDR_W'(MISC_ADDR));
    stb.miscRd = rdEn && (addr == ADDR_W'(MISC_ADDR));
    stb.statRd = rdEn && (addr == ADDR_W'(STATUS_ADDR));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                attrPhase <= 1'b0;
    else if (stb.statRd)      attrPhase <= 1'b0;
    else if (wrEn && attrHit) attrPhase <= !attrPhase;
  end
endmodule

// File: rtl/disp_regdec_dp.sv
module disp_regdec_dp
  import disp_regdec_pkg::*;
#(
  parameter int INDEX_W = 8,
  localparam int DEPTH = 1 << INDEX_W,
  localparam int FLAT_W = NBANK * DEPTH * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        wdata,
  input  logic              attrPhase,
  output logic [7:0]        rdData,
  output logic [7:0]        miscOut,
  output logic              videoEnable,
  output logic [FLAT_W-1:0] regFlat
);
  logic [NBANK*INDEX_W-1:0] idxBus;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [INDEX_W-1:0] idxQ;
    logic [7:0]         mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        idxQ <= '0;
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
        if (stb.idxWr[b]) idxQ <= wdata[INDEX_W-1:0];
        if (stb.datWr[b]) mem[idxQ] <= wdata;
      end
    end

    assign idxBus[b*INDEX_W +: INDEX_W] = idxQ;
    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
      assign regFlat[(b*DEPTH+i)*8 +: 8] = mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      miscOut     <= '0;
      videoEnable <= 1'b0;
    end else begin
      if (stb.miscWr) miscOut <= wdata;
      if (stb.idxWr[ATTR_BANK]) videoEnable <= wdata[5];
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NBANK; b++)
      if (stb.idxRd[b]) rdData = 8'(idxBus[b*INDEX_W +: INDEX_W]);
    if (stb.miscRd) rdData = miscOut;
    if (stb.statRd) rdData = {7'b0, attrPhase};
  end
endmodule

// File: rtl/disp_reg_decoder.sv
module disp_reg_decoder
  import disp_regdec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int INDEX_W = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [7:0]                         wdata,
  input  logic                               wrEn,
  input  logic                               rdEn,
  output logic [7:0]                         rdData,
  output logic [7:0]                         miscOut,
  output logic                               videoEnable,
  output logic [NBANK*(2**INDEX_W)*8-1:0]    regFlat
);
  strobe_t stb;
  logic    attrPhase;

  disp_regdec_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .stb(stb), .attrPhase(attrPhase)
  );

  disp_regdec_dp #(.INDEX_W(INDEX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(wdata), .attrPhase(attrPhase),
    .rdData(rdData), .miscOut(miscOut), .videoEnable(videoEnable),
    .regFlat(regFlat)
  );
endmodule

// File: rtl/disp_regdec_checker.sv
module disp_regdec_checker
  import disp_regdec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int INDEX_W = 8
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [ADDR_W-1:0]               addr,
  input logic                            wrEn,
  input logic                            rdEn,
  input logic [7:0]                      rdData,
  input logic [7:0]                      miscOut,
  input logic                            videoEnable,
  input logic [NBANK*(2**INDEX_W)*8-1:0] regFlat,
  input logic                            attrPhase,
  input strobe_t                         stb
);
  logic attrW, statR, readHit;
  assign attrW = wrEn && (addr == ADDR_W'(ATTR_ADDR));
  assign statR = rdEn && (addr == ADDR_W'(STATUS_ADDR));

  always_comb begin
    readHit = (addr == ADDR_W'(ATTR_ADDR)) || (addr == ADDR_W'(MISC_ADDR)) ||
              (addr == ADDR_W'(STATUS_ADDR));
    for (int b = 0; b < NBANK - 1; b++)
      if (addr == ADDR_W'(idxAddr(b))) readHit = 1'b1;
  end

  p_attr_flip_r5: assert property (@(posedge clk) disable iff (!rstN)
    attrW |=> attrPhase != $past(attrPhase));
  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!attrW && !statR) |=> $stable(attrPhase));
  p_status_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    statR |=> !attrPhase);
  p_one_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.idxWr, stb.datWr, stb.miscWr}));
  p_flat_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(regFlat));
  p_misc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'(MISC_ADDR)) |=> $stable(miscOut));
  p_video_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(attrW && !attrPhase) |=> $stable(videoEnable));
  p_quiet_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn || !readHit) |-> rdData == 8'h00);
endmodule

bind disp_reg_decoder disp_regdec_checker #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .miscOut(miscOut), .videoEnable(videoEnable),
  .regFlat(regFlat), .attrPhase(attrPhase), .stb(stb)
);

// File: tb/tb_disp_reg_decoder.sv
module tb_disp_reg_decoder;
  localparam int IW = 4;
  localparam int DEP = 1 << IW;
  localparam int NB = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData, miscOut;
  logic videoEnable;
  logic [NB*DEP*8-1:0] regFlat;

  disp_reg_decoder #(.ADDR_W(12), .INDEX_W(IW)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .miscOut(miscOut),
    .videoEnable(videoEnable), .regFlat(regFlat)
  );

  always #5 clk = !clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [11:0] a; logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];

  // Reference state derived from the requirements.
  logic [7:0]    mdl [NB][DEP];
  logic [IW-1:0] mIdx [NB];
  logic mPhase, mVid;
  logic [7:0] mMisc;

  function automatic int idxBank(input logic [11:0] a);
    case (a)
      12'h7AC: return 0; 12'h7A0: return 1; 12'h7A8: return 2;
      12'h79C: return 3; 12'h788: return 4; default: return -1;
    endcase
  endfunction

  function automatic int datBank(input logic [11:0] a);
    case (a)
      12'h7AD: return 0; 12'h7A1: return 1; 12'h7A9: return 2;
      12'h79D: return 3; 12'h789: return 4; default: return -1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    int ib, db;
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1; rdEn = 1'b0;
    ib = idxBank(a); db = datBank(a);
    if (ib >= 0) mIdx[ib] = d[IW-1:0];
    else if (db >= 0) mdl[db][mIdx[db]] = d;
    else if (a == 12'h780) begin
      if (!mPhase) begin mIdx[5] = d[IW-1:0]; mVid = d[5]; end
      else mdl[5][mIdx[5]] = d;
      mPhase = !mPhase;
    end else if (a == 12'h784) mMisc = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    item_t it;
    int ib;
    it.a = a; it.tag = tag; it.exp = 8'h00;
    ib = idxBank(a);
    if (ib >= 0) it.exp = 8'(mIdx[ib]);
    else if (a == 12'h780) it.exp = 8'(mIdx[5]);
    else if (a == 12'h784) it.exp = mMisc;
    else if (a == 12'h7B4) begin it.exp = {7'b0, mPhase}; mPhase = 1'b0; end
    @(negedge clk);
    addr = a; rdEn = 1'b1; wrEn = 1'b0;
    sbq.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkFlat(input string tag);
    int bad = 0;
    #1;
    checks++;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < DEP; i++)
        if (regFlat[(b*DEP+i)*8 +: 8] !== mdl[b][i]) begin
          bad++;
          $display("FAIL %s bank %0d reg %0d actual %0h expected %0h",
                   tag, b, i, regFlat[(b*DEP+i)*8 +: 8], mdl[b][i]);
        end
    if (bad != 0) errors++;
  endtask

  // Monitor: compares read results against queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rdEn) begin
        if (sbq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected read actual %0h expected none", rdData);
        end else begin
          item_t it;
          it = sbq.pop_front();
          check($sformatf("%s read %0h", it.tag, it.a), 32'(rdData), 32'(it.exp));
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [11:0] pool [14];
    for (int b = 0; b < NB; b++) begin
      mIdx[b] = '0;
      for (int i = 0; i < DEP; i++) mdl[b][i] = '0;
    end
    mPhase = 0; mVid = 0; mMisc = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkFlat("R1 reset image");
    check("R1 misc reset", 32'(miscOut), 0);
    check("R1 video reset", 32'(videoEnable), 0);
    rd(12'h7B4, "R1 phase reset");
    rd(12'h7A8, "R1 index reset");

    // R2/R3/R4 paired banks, index bytes with upper bits set
    for (int b = 0; b < 5; b++) begin
      logic [11:0] ia;
      ia = (b == 0) ? 12'h7AC : (b == 1) ? 12'h7A0 : (b == 2) ? 12'h7A8 :
           (b == 3) ? 12'h79C : 12'h788;
      wr(ia, 8'hF0 | 8'(b + 3));
      rd(ia, "R2 index truncated");
      wr(ia + 12'd1, 8'hA0 + 8'(b));
      checkFlat("R3 R4 data lands in selected register");
    end
    // R10 repeated data writes, same register
    wr(12'h7A1, 8'h11);
    wr(12'h7A1, 8'h22);
    checkFlat("R10 last data write wins");
    rd(12'h7A0, "R10 index unchanged");

    // R5/R6/R7 attribute port
    wr(12'h780, 8'h20);
    #1 check("R7 video enable set", 32'(videoEnable), 1);
    wr(12'h780, 8'h5A);
    #1 check("R7 data write keeps video", 32'(videoEnable), 1);
    checkFlat("R5 attribute data");
    wr(12'h780, 8'h03);
    #1 check("R7 video cleared", 32'(videoEnable), 0);
    rd(12'h780, "R5 attribute index");
    rd(12'h7B4, "R6 phase data");
    rd(12'h7B4, "R6 phase cleared");
    wr(12'h780, 8'h07);
    wr(12'h780, 8'h99);
    checkFlat("R6 realigned index then data");

    // R8 misc register
    wr(12'h784, 8'hC7);
    #1 check("R8 misc out", 32'(miscOut), 32'h0C7);
    rd(12'h784, "R8 misc read");

    // R9 undecoded and write-only offsets
    wr(12'h7B0, 8'hFF);
    wr(12'h7AE, 8'hFF);
    wr(12'h000, 8'hFF);
    checkFlat("R9 undecoded writes ignored");
    #1 check("R9 misc untouched", 32'(miscOut), 32'h0C7);
    rd(12'h7B0, "R9 undecoded read");
    rd(12'h7AD, "R9 data port read");
    #1 check("R9 idle read zero", 32'(rdData), 0);

    // Mixed pseudo-random run
    pool = '{12'h7AC, 12'h7AD, 12'h7A0, 12'h7A1, 12'h7A8, 12'h7A9, 12'h79C,
             12'h79D, 12'h788, 12'h789, 12'h780, 12'h784, 12'h7B4, 12'h7B0};
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      int sel;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sel = int'(lf[3:0]) % 14;
      if (pool[sel] == 12'h7B4) rd(12'h7B4, "R6 mixed status");
      else wr(pool[sel], lf[15:8]);
    end
    checkFlat("R3 R5 mixed run image");
    #1 check("R7 mixed video", 32'(videoEnable), 32'(mVid));
    rd(12'h7B4, "R5 mixed phase");

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", sbq.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule